// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the serial receiver of a small graphics panel controller. Each received byte arrives with a one-cycle valid strobe and a select level. With the select level low the byte belongs to the command stream. With it high the byte is pixel data, and pixel data is handled elsewhere. The command stream is a series of variable-length commands. Each command is an opcode byte followed by zero, one or two parameter bytes. The decoder gathers the parameter bytes one by one and executes the command once the last one arrives.

Executed commands update a small set of registers that the address generator and the panel driver read:
- the column window and the row window, each reduced modulo the panel geometry;
- a remap byte, whose vertical-increment bit is brought out separately;
- the contrast level;
- the display on/off state.

A load strobe tells the address generator to reset its current column or current row to the new window start. Analog tuning commands are consumed with their parameter and have no effect. An unrecognised opcode raises a one-cycle error strobe.

Top module: `oled_cmd_decoder`

## Requirements
- R1: A byte presented while `sel_data` is 1 is pixel data. It changes no output and does not advance command collection.
- R2: Opcode 0x15 takes two parameters, column start then column end. Each is reduced modulo COLS (64). Both are written to `col_start`/`col_end`, and `col_load` pulses high for one cycle.
- R3: Opcode 0x75 takes two parameters, row start then row end. Each is reduced modulo ROWS (80). Both are written to `row_start`/`row_end`, and `row_load` pulses high for one cycle.
- R4: Opcode 0xA0 takes one parameter, which is stored in `remap`. `vert_inc` equals bit 2 of `remap`.
- R5: Opcode 0x81 takes one parameter, which is stored in `contrast`.
- R6: Opcode 0xAF sets `display_on` to 1 and 0xAE clears it. Opcode 0xE3 takes no parameter and changes nothing.
- R7: Opcodes 0x84, 0x85, 0x86, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one parameter byte and change no output. That parameter byte is never read as an opcode.
- R8: Any other opcode pulses `bad_opcode` for one cycle, changes no register, and consumes no parameter.
- R9: A change of `sel_data` while a command is partly received discards that command. The next command byte is then read as an opcode.
- R10: After reset the outputs are: column window 0..COLS-1, row window 0..ROWS-1, `remap` 0, `contrast` 0, display off, and all strobes low.
- R11: No register changes until the final parameter byte of a command has arrived. After a command completes, the next command byte is read as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| byte_data | input | 8 | Received byte |
| sel_data | input | 1 | 1: byte is pixel data, 0: byte is command stream |
| col_start | output | COL_W | Column window start |
| col_end | output | COL_W | Column window end |
| row_start | output | ROW_W | Row window start |
| row_end | output | ROW_W | Row window end |
| col_load | output | 1 | Pulse: load current column from `col_start` |
| row_load | output | 1 | Pulse: load current row from `row_start` |
| remap | output | 8 | Remap byte |
| vert_inc | output | 1 | Vertical address increment selected |
| contrast | output | 8 | Contrast level |
| display_on | output | 1 | Display enabled |
| bad_opcode | output | 1 | Pulse: unrecognised opcode received |

## Verification
Every result lands on the clock edge that samples the final byte of its command. This holds for the register updates, the load strobes and the error strobe, so each is visible one cycle after that byte is presented. A strobe lasts exactly that one cycle. The bench drives bytes on the falling edge. A behavioural model updates on the rising edge from the same inputs. Every output is compared against the model on each following falling edge, so a result that lands one cycle early or late fails the comparison. Directed checks read the outputs at the falling edge right after the final byte and confirm intermediate states, such as the state after the first of two parameters.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_COL,
        K_ROW,
        K_REMAP,
        K_CONTRAST,
        K_DISP_OFF,
        K_DISP_ON,
        K_BAD
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [1:0] nparam;
    } cmd_info_t;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [7:0] p0;
        logic [7:0] p1;
    } cmd_exec_t;

    function automatic cmd_info_t classify(input logic [7:0] op);
        cmd_info_t r;
        unique case (op)
            8'h15:                      r = '{kind: K_COL,      nparam: 2'd2};
            8'h75:                      r = '{kind: K_ROW,      nparam: 2'd2};
            8'hA0:                      r = '{kind: K_REMAP,    nparam: 2'd1};
            8'h81:                      r = '{kind: K_CONTRAST, nparam: 2'd1};
            8'h84, 8'h85, 8'h86,
            8'hA8, 8'hAD, 8'hB1,
            8'hB2, 8'hB3, 8'hBC,
            8'hBE, 8'hBF:               r = '{kind: K_NONE,     nparam: 2'd1};
            8'hE3:                      r = '{kind: K_NONE,     nparam: 2'd0};
            8'hAE:                      r = '{kind: K_DISP_OFF, nparam: 2'd0};
            8'hAF:                      r = '{kind: K_DISP_ON,  nparam: 2'd0};
            default:                    r = '{kind: K_BAD,      nparam: 2'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oled_cmd_collect.sv
module oled_cmd_collect
    import oled_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       sel_data,
    output logic       exec_valid,
    output cmd_exec_t  exec
);

    logic       sel_q;
    logic       busy;
    logic [1:0] need;
    logic [1:0] got;
    cmd_kind_e  kind_q;
    logic [7:0] p0_q;

    logic      abort;
    logic      cmd_byte;
    logic      mid;
    cmd_info_t info;

    assign abort    = (sel_data != sel_q);
    assign cmd_byte = byte_valid && !sel_data;
    assign mid      = busy && !abort;
    assign info     = classify(byte_data);

    always_comb begin
        exec_valid = 1'b0;
        exec       = '{kind: kind_q, p0: p0_q, p1: byte_data};
        if (cmd_byte) begin
            if (!mid) begin
                if (info.nparam == 2'd0) begin
                    exec_valid = 1'b1;
                    exec.kind  = info.kind;
                end
            end else if (got + 2'd1 == need) begin
                exec_valid = 1'b1;
                if (need == 2'd1) begin
                    exec.p0 = byte_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            busy   <= 1'b0;
            need   <= 2'd0;
            got    <= 2'd0;
            kind_q <= K_NONE;
            p0_q   <= 8'h00;
        end else begin
            sel_q <= sel_data;
            if (abort) begin
                busy <= 1'b0;
            end
            if (cmd_byte) begin
                if (!mid) begin
                    if (info.nparam != 2'd0) begin
                        busy   <= 1'b1;
                        need   <= info.nparam;
                        got    <= 2'd0;
                        kind_q <= info.kind;
                    end
                end else if (exec_valid) begin
                    busy <= 1'b0;
                    got  <= 2'd0;
                end else begin
                    got  <= got + 2'd1;
                    p0_q <= byte_data;
                end
            end
        end
    end

    AST_GOT_BELOW_NEED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (got < need));                                        // R11
    AST_SEL_RISE_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (sel_data && !sel_q) |=> !busy);                               // R9
    AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && sel_data) |-> !exec_valid);                     // R1

endmodule

// File: rtl/oled_cmd_regs.sv
module oled_cmd_regs
    import oled_cmd_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_valid,
    input  cmd_exec_t        exec,
    output logic [COL_W-1:0] col_start,
    output logic [COL_W-1:0] col_end,
    output logic [ROW_W-1:0] row_start,
    output logic [ROW_W-1:0] row_end,
    output logic             col_load,
    output logic             row_load,
    output logic [7:0]       remap,
    output logic [7:0]       contrast,
    output logic             display_on,
    output logic             bad_opcode
);

    localparam logic [7:0] COL_MOD = 8'(COLS);
    localparam logic [7:0] ROW_MOD = 8'(ROWS);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_start  <= '0;
            col_end    <= COL_W'(COLS - 1);
            row_start  <= '0;
            row_end    <= ROW_W'(ROWS - 1);
            col_load   <= 1'b0;
            row_load   <= 1'b0;
            remap      <= 8'h00;
            contrast   <= 8'h00;
            display_on <= 1'b0;
            bad_opcode <= 1'b0;
        end else begin
            col_load   <= 1'b0;
            row_load   <= 1'b0;
            bad_opcode <= 1'b0;
            if (exec_valid) begin
                unique case (exec.kind)
                    K_COL: begin
                        col_start <= COL_W'(exec.p0 % COL_MOD);
                        col_end   <= COL_W'(exec.p1 % COL_MOD);
                        col_load  <= 1'b1;
                    end
                    K_ROW: begin
                        row_start <= ROW_W'(exec.p0 % ROW_MOD);
                        row_end   <= ROW_W'(exec.p1 % ROW_MOD);
                        row_load  <= 1'b1;
                    end
                    K_REMAP:    remap      <= exec.p0;
                    K_CONTRAST: contrast   <= exec.p0;
                    K_DISP_OFF: display_on <= 1'b0;
                    K_DISP_ON:  display_on <= 1'b1;
                    K_BAD:      bad_opcode <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    AST_ROW_START_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(row_start) < ROWS);                                        // R3
    AST_ROW_END_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(row_end) < ROWS);                                          // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({col_load, row_load, bad_opcode}));                   // R8
    AST_BAD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        bad_opcode |-> ($stable(contrast) && $stable(display_on) && $stable(remap))); // R8
    AST_COL_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        col_load |=> !col_load);                                       // R2

endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
    import oled_cmd_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             sel_data,
    output logic [COL_W-1:0] col_start,
    output logic [COL_W-1:0] col_end,
    output logic [ROW_W-1:0] row_start,
    output logic [ROW_W-1:0] row_end,
    output logic             col_load,
    output logic             row_load,
    output logic [7:0]       remap,
    output logic             vert_inc,
    output logic [7:0]       contrast,
    output logic             display_on,
    output logic             bad_opcode
);

    logic      exec_valid;
    cmd_exec_t exec;

    oled_cmd_collect u_collect (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .sel_data   (sel_data),
        .exec_valid (exec_valid),
        .exec       (exec)
    );

    oled_cmd_regs #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .exec_valid (exec_valid),
        .exec       (exec),
        .col_start  (col_start),
        .col_end    (col_end),
        .row_start  (row_start),
        .row_end    (row_end),
        .col_load   (col_load),
        .row_load   (row_load),
        .remap      (remap),
        .contrast   (contrast),
        .display_on (display_on),
        .bad_opcode (bad_opcode)
    );

    assign vert_inc = remap[2];

    AST_DATA_KEEPS_CONTRAST: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && sel_data) |=> $stable(contrast));               // R1

endmodule

// File: tb/oled_cmd_decoder_tb.sv
module oled_cmd_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       sel_data = 1'b0;

    logic [5:0] col_start, col_end;
    logic [6:0] row_start, row_end;
    logic       col_load, row_load, vert_inc, display_on, bad_opcode;
    logic [7:0] remap, contrast;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    oled_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .sel_data(sel_data), .col_start(col_start), .col_end(col_end),
        .row_start(row_start), .row_end(row_end), .col_load(col_load),
        .row_load(row_load), .remap(remap), .vert_inc(vert_inc),
        .contrast(contrast), .display_on(display_on), .bad_opcode(bad_opcode)
    );

    // Behavioural reference model
    int      m_cs, m_ce, m_rs, m_re, m_remap, m_con;
    int      m_on, m_cl, m_rl, m_err;
    int      m_need;
    int      m_op;
    int      m_sel_q;
    int      pq[$];

    function automatic int need_of(input int op);
        case (op)
            'h15, 'h75: return 2;
            'hA0, 'h81, 'h84, 'h85, 'h86, 'hA8, 'hAD,
            'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic m_exec();
        case (m_op)
            'h15: begin m_cs = pq[0] % 64; m_ce = pq[1] % 64; m_cl = 1; end
            'h75: begin m_rs = pq[0] % 80; m_re = pq[1] % 80; m_rl = 1; end
            'hA0: m_remap = pq[0];
            'h81: m_con = pq[0];
            'hAE: m_on = 0;
            'hAF: m_on = 1;
            'hE3, 'h84, 'h85, 'h86, 'hA8, 'hAD,
            'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: ;
            default: m_err = 1;
        endcase
        m_need = -1;
        pq.delete();
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cs = 0; m_ce = 63; m_rs = 0; m_re = 79; m_remap = 0; m_con = 0;
            m_on = 0; m_cl = 0; m_rl = 0; m_err = 0; m_need = -1; m_sel_q = 0;
            pq.delete();
        end else begin
            m_cl = 0; m_rl = 0; m_err = 0;
            if (int'(sel_data) != m_sel_q) begin
                m_need = -1;
                pq.delete();
            end
            m_sel_q = int'(sel_data);
            if (byte_valid && !sel_data) begin
                if (m_need < 0) begin
                    m_op = int'(byte_data);
                    m_need = need_of(m_op);
                    if (m_need == 0) m_exec();
                end else begin
                    pq.push_back(int'(byte_data));
                    if (pq.size() == m_need) m_exec();
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model every clock, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(col_start) == m_cs, "R2 col_start", int'(col_start), m_cs);
            chk(int'(col_end) == m_ce, "R2 col_end", int'(col_end), m_ce);
            chk(int'(col_load) == m_cl, "R2 col_load", int'(col_load), m_cl);
            chk(int'(row_start) == m_rs, "R3 row_start", int'(row_start), m_rs);
            chk(int'(row_end) == m_re, "R3 row_end", int'(row_end), m_re);
            chk(int'(row_load) == m_rl, "R3 row_load", int'(row_load), m_rl);
            chk(int'(remap) == m_remap, "R4 remap", int'(remap), m_remap);
            chk(int'(vert_inc) == ((m_remap >> 2) & 1), "R4 vert_inc",
                int'(vert_inc), (m_remap >> 2) & 1);
            chk(int'(contrast) == m_con, "R5 contrast", int'(contrast), m_con);
            chk(int'(display_on) == m_on, "R6 display_on", int'(display_on), m_on);
            chk(int'(bad_opcode) == m_err, "R8 bad_opcode", int'(bad_opcode), m_err);
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic set_sel(input logic v);
        @(negedge clk);
        sel_data = v;
        @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(col_start == 0 && col_end == 63, "R10 col window", int'(col_end), 63);
        chk(row_start == 0 && row_end == 79, "R10 row window", int'(row_end), 79);
        chk(remap == 0 && contrast == 0 && !display_on, "R10 regs", int'(contrast), 0);
        chk(!col_load && !row_load && !bad_opcode, "R10 strobes", int'(bad_opcode), 0);

        // R2 / R11 column window
        send(8'h15); send(8'h05);
        chk(col_start == 0 && !col_load, "R11 no update mid-command", int'(col_start), 0);
        send(8'h3A);
        chk(col_start == 5 && col_end == 58 && col_load, "R2 window", int'(col_end), 58);
        send(8'h15); send(8'h45); send(8'hFF);
        chk(col_start == 5 && col_end == 63, "R2 modulo", int'(col_end), 63);

        // R3 row window with modulo 80
        send(8'h75); send(8'h10); send(8'h60);
        chk(row_start == 16 && row_end == 16 && row_load, "R3 window", int'(row_end), 16);
        send(8'h75); send(8'hA0); send(8'h9F);
        chk(row_start == 0 && row_end == 79, "R3 modulo", int'(row_end), 79);

        // R4 remap
        send(8'hA0); send(8'h04);
        chk(vert_inc == 1'b1 && remap == 8'h04, "R4 vertical", int'(vert_inc), 1);
        send(8'hA0); send(8'h13);
        chk(vert_inc == 1'b0 && remap == 8'h13, "R4 horizontal", int'(remap), 'h13);

        // R5 contrast
        send(8'h81); send(8'h7F);
        chk(contrast == 8'h7F, "R5 contrast", int'(contrast), 'h7F);

        // R6 display control and no-op
        send(8'hAF);
        chk(display_on, "R6 on", int'(display_on), 1);
        send(8'hE3);
        chk(display_on && contrast == 8'h7F, "R6 nop", int'(display_on), 1);
        send(8'hAE);
        chk(!display_on, "R6 off", int'(display_on), 0);

        // R7 ignored opcodes swallow one parameter
        send(8'hB1); send(8'hAF);
        chk(!display_on, "R7 param not opcode", int'(display_on), 0);
        send(8'h84); send(8'hAF);
        chk(!display_on, "R7 range opcode", int'(display_on), 0);
        send(8'hAF);
        chk(display_on, "R11 next is opcode", int'(display_on), 1);

        // R8 unknown opcode
        send(8'hA4);
        chk(bad_opcode, "R8 error pulse", int'(bad_opcode), 1);
        send(8'h81); send(8'h22);
        chk(contrast == 8'h22, "R8 no param consumed", int'(contrast), 'h22);

        // R9 abort on select change
        send(8'h81);
        set_sel(1'b1);
        send(8'hAE);
        set_sel(1'b0);
        send(8'hAE);
        chk(!display_on && contrast == 8'h22, "R9 abort", int'(contrast), 'h22);

        // R1 pixel data has no effect
        set_sel(1'b1);
        send(8'h81); send(8'h55); send(8'hAF);
        chk(contrast == 8'h22 && !display_on, "R1 data ignored", int'(contrast), 'h22);
        set_sel(1'b0);
        send(8'hAF);
        chk(display_on, "R1 command resumes", int'(display_on), 1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule